// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block runs one DMA channel's scatter-gather list. Once a start request arrives with a list base address, it reads 8-byte descriptors one at a time through a single-beat memory read port. Descriptors sit back to back, 8 bytes apart. The block checks each descriptor it fetches. For each transfer entry it hands the buffer address and byte count to an external data mover, and it waits for that mover to report the element complete before it reads the next descriptor.

The walk stops in one of three ways. If the entry flagged as last finishes, the block pulses done. If a descriptor is malformed, the block raises a sticky error flag and issues no transfer for that entry. If abort is asserted, the block drops all requests and goes back to idle without a done pulse. A start request that arrives during a walk has no effect.

Top module: `sg_list_walker`

## Requirements
- R1: When the walker is idle and start_i is high at a clock edge, it latches list_base_i. In the cycle after that edge, busy_o is high, mem_req_o is high and mem_addr_o equals the latched base.
- R2: Byte k of a descriptor arrives on mem_rdata_i[8k+7:8k]. Byte 0 holds the flags: bit 0 is valid, bit 1 is last and bit 5 is transfer. Bytes 2 and 3 hold the byte length, least significant byte first. Bytes 4 to 7 hold the 32-bit buffer address, with byte 4 as the least significant byte. xfer_addr_o and xfer_len_o present these two fields.
- R3: Each valid transfer entry produces exactly one request. xfer_req_o stays high, with xfer_addr_o and xfer_len_o stable, until the cycle in which xfer_ack_i is high.
- R4: mem_req_o and mem_addr_o stay steady until mem_ack_i. The next descriptor is read at the previous address plus 8, and only after xfer_ack_i for the current element. mem_req_o and xfer_req_o are never high together.
- R5: A valid descriptor whose transfer bit is clear issues no transfer. The walk then goes on to the next descriptor, or it ends with done if that descriptor carries the last bit.
- R6: In the cycle after xfer_ack_i for the last entry, done_o is high for exactly one cycle and busy_o is low. No further fetch follows.
- R7: A fetched descriptor with the valid bit clear ends the walk: err_o goes high, busy_o goes low, and no transfer or done follows.
- R8: A length field that is not a multiple of 4 is handled the same way as R7.
- R9: err_o stays high until the next accepted start and is low in the cycle after that start.
- R10: If abort_i is high at a clock edge, then in the next cycle busy_o, mem_req_o, xfer_req_o and done_o are all low.
- R11: start_i while busy_o is high is ignored: the fetch addresses and transfers of the running walk are unchanged.
- R12: After reset, busy_o, done_o, err_o, mem_req_o and xfer_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (honoured only when idle) |
| list_base_i | input | 32 | Address of the first descriptor |
| abort_i | input | 1 | Stop the walk and return to idle |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | The whole 8-byte descriptor |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| xfer_addr_o | output | 32 | Buffer address of the element |
| xfer_len_o | output | 16 | Byte length of the element |
| xfer_ack_i | input | 1 | Data mover reports the element complete |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a successful walk |
| err_o | output | 1 | Sticky flag for a malformed descriptor |

## Verification
Every result comes from a register and is due one cycle after the edge that causes it. The first fetch follows the start edge. A descriptor is decoded one cycle after the edge that accepts its read. A transfer request follows that decode, and done, or the next fetch, follows the edge of the transfer acknowledge. Error and the return to idle follow the decode edge, and idle follows the abort edge. The bench drives every input and every responder acknowledge on the falling edge and samples outputs on the falling edge after the rising edge that should change them. It records every fetch address and every transfer request in logs and compares those logs with lists it builds from the descriptors it wrote into its memory model.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECODE = 2'd2,
    ST_XFER   = 2'd3
  } sgw_state_e;

  // byte positions inside a descriptor
  localparam int FLAG_BYTE = 0;
  localparam int LEN_BYTE  = 2;
  localparam int ADDR_BYTE = 4;

  // bit positions inside the flag byte
  localparam int FLG_VALID = 0;
  localparam int FLG_LAST  = 1;
  localparam int FLG_XFER  = 5;

  typedef struct packed {
    logic valid;
    logic last;
    logic xfer;
    logic misalign;
  } sgw_flags_t;
endpackage

// File: rtl/sgw_desc_reg.sv
module sgw_desc_reg
  import sgw_pkg::*;
#(
  parameter int DESC_BYTES  = 8,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int ALIGN_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [DESC_BYTES*8-1:0] rdata,
  output logic [ADDR_W-1:0]       buf_addr,
  output logic [LEN_W-1:0]        buf_len,
  output sgw_flags_t              flags,
  output logic                    bad
);
  localparam int DESC_W    = DESC_BYTES * 8;
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic [DESC_W-1:0] desc_q, desc_d;

  always_comb begin
    desc_d = desc_q;
    if (cap_en) desc_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_q <= '0;
    else        desc_q <= desc_d;
  end

  logic [7:0] flag_byte;
  assign flag_byte = desc_q[FLAG_BYTE*8 +: 8];
  assign buf_len   = desc_q[LEN_BYTE*8 +: LEN_W];
  assign buf_addr  = desc_q[ADDR_BYTE*8 +: ADDR_W];

  logic mis;
  generate
    if (ALIGN_LSB == 0) begin : g_noalign
      assign mis = 1'b0;
    end else begin : g_align
      assign mis = |buf_len[ALIGN_LSB-1:0];
    end
  endgenerate

  always_comb begin
    flags.valid    = flag_byte[FLG_VALID];
    flags.last     = flag_byte[FLG_LAST];
    flags.xfer     = flag_byte[FLG_XFER];
    flags.misalign = mis;
  end

  assign bad = !flags.valid || flags.misalign;
endmodule

// File: rtl/sgw_ptr.sv
module sgw_ptr #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = base;
    else if (adv) ptr_d = ptr_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/sgw_fsm.sv
module sgw_fsm
  import sgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       mem_ack,
  input  logic       xfer_ack,
  input  sgw_flags_t flags,
  input  logic       bad,
  output logic       cap_en,
  output logic       load,
  output logic       adv,
  output logic       mem_req,
  output logic       xfer_req,
  output logic       busy,
  output logic       done,
  output logic       err
);
  sgw_state_e st_q, st_d;
  logic       done_q, done_d;
  logic       err_q, err_d;
  logic       accept;

  assign accept = (st_q == ST_IDLE) && start && !abort;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = err_q;
    adv    = 1'b0;
    if (accept) err_d = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_FETCH;
      ST_FETCH: if (mem_ack) st_d = ST_DECODE;
      ST_DECODE: begin
        if (bad) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else if (flags.xfer) begin
          st_d = ST_XFER;
        end else if (flags.last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_FETCH;
          adv  = 1'b1;
        end
      end
      ST_XFER: begin
        if (xfer_ack) begin
          if (flags.last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_FETCH;
            adv  = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
      adv    = 1'b0;
      err_d  = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign load     = accept;
  assign cap_en   = (st_q == ST_FETCH) && mem_ack;
  assign mem_req  = (st_q == ST_FETCH);
  assign xfer_req = (st_q == ST_XFER);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DESC_BYTES  = 8,
  parameter int ALIGN_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       list_base_i,
  input  logic                    abort_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [DESC_BYTES*8-1:0] mem_rdata_i,
  output logic                    xfer_req_o,
  output logic [ADDR_W-1:0]       xfer_addr_o,
  output logic [LEN_W-1:0]        xfer_len_o,
  input  logic                    xfer_ack_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o
);
  sgw_flags_t flags;
  logic       bad, cap_en, load, adv;

  sgw_desc_reg #(
    .DESC_BYTES(DESC_BYTES), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .ALIGN_BYTES(ALIGN_BYTES)
  ) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .rdata(mem_rdata_i),
    .buf_addr(xfer_addr_o), .buf_len(xfer_len_o), .flags(flags), .bad(bad)
  );

  sgw_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .base(list_base_i), .ptr(mem_addr_o)
  );

  sgw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .abort(abort_i),
    .mem_ack(mem_ack_i), .xfer_ack(xfer_ack_i), .flags(flags), .bad(bad),
    .cap_en(cap_en), .load(load), .adv(adv), .mem_req(mem_req_o),
    .xfer_req(xfer_req_o), .busy(busy_o), .done(done_o), .err(err_o)
  );
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              abort_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              xfer_req_o,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic [LEN_W-1:0]  xfer_len_o,
  input logic              xfer_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  p_xfer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_ack_i && !abort_i) |=>
      (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !abort_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && xfer_req_o));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && !done_o && !xfer_req_o));

  p_len_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> (xfer_len_o[1:0] == 2'b00));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !mem_req_o && !xfer_req_o && !done_o));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && xfer_req_o && !xfer_ack_i && !abort_i) |=> xfer_req_o);
endmodule

bind sg_list_walker sgw_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
  .xfer_ack_i(xfer_ack_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_sg_list_walker.sv
`timescale 1ns/1ps
module sim_sg_list_walker;
  logic        clk, rst_n, start_i, abort_i, mem_ack_i, xfer_ack_i;
  logic [31:0] list_base_i, mem_addr_o, xfer_addr_o;
  logic [63:0] mem_rdata_i;
  logic [15:0] xfer_len_o;
  logic        mem_req_o, xfer_req_o, busy_o, done_o, err_o;

  sg_list_walker u0 (.*);

  localparam logic [7:0] F_V = 8'h01, F_L = 8'h02, F_X = 8'h20;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] mem [0:31];
  logic [31:0] fa [0:15];
  logic [31:0] xa [0:15];
  logic [15:0] xl [0:15];
  int fn = 0, xn = 0, done_seen = 0, dbl = 0, xlat = 0, wcnt = 0;
  logic prev_done = 1'b0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] mkd(input logic [7:0] f, input logic [15:0] l,
                                      input logic [31:0] a);
    return {a, l, 8'h00, f};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        finish_run();
      end
    end
  end

  // descriptor memory responder
  initial begin
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = mem[mem_addr_o[7:3]];
        if (fn < 16) fa[fn] = mem_addr_o;
        fn++;
      end else mem_ack_i = 1'b0;
    end
  end

  // data mover responder with latency xlat
  initial begin
    xfer_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (xfer_req_o && !xfer_ack_i) begin
        if (wcnt >= xlat) begin
          xfer_ack_i = 1'b1;
          if (xn < 16) begin xa[xn] = xfer_addr_o; xl[xn] = xfer_len_o; end
          xn++;
          wcnt = 0;
        end else wcnt++;
      end else begin
        xfer_ack_i = 1'b0;
        if (!xfer_req_o) wcnt = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        done_seen++;
        if (prev_done) dbl++;
      end
      prev_done = done_o;
    end
  end

  task automatic clear_logs();
    fn = 0; xn = 0; done_seen = 0; dbl = 0;
  endtask

  task automatic start_walk(input logic [31:0] base);
    clear_logs();
    @(negedge clk);
    start_i = 1'b1; list_base_i = base;
    @(negedge clk);
    start_i = 1'b0; list_base_i = 32'h0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 busy after reset", {31'b0, busy_o}, 0);
    chk("R12 done after reset", {31'b0, done_o}, 0);
    chk("R12 err after reset", {31'b0, err_o}, 0);
    chk("R12 reqs after reset", {30'b0, mem_req_o, xfer_req_o}, 0);
  endtask

  task automatic t_basic();
    xlat = 2;
    mem[8]  = mkd(F_V | F_X, 16'h0100, 32'h1000_0000);
    mem[9]  = mkd(F_V | F_X, 16'h0044, 32'h2000_0010);
    mem[10] = mkd(F_V | F_X | F_L, 16'h0008, 32'h3000_0020);
    start_walk(32'h40);
    chk("R1 busy after start", {31'b0, busy_o}, 1);
    chk("R1 first fetch req", {31'b0, mem_req_o}, 1);
    chk("R1 first fetch addr", mem_addr_o, 32'h40);
    wait_idle();
    chk("R4 fetch count", fn, 3);
    chk("R4 fetch addr 1", fa[1], 32'h48);
    chk("R4 fetch addr 2", fa[2], 32'h50);
    chk("R3 transfer count", xn, 3);
    chk("R2 addr 0", xa[0], 32'h1000_0000);
    chk("R2 len 0", {16'b0, xl[0]}, 32'h100);
    chk("R2 addr 2", xa[2], 32'h3000_0020);
    chk("R2 len 1", {16'b0, xl[1]}, 32'h44);
    chk("R6 one done pulse", done_seen, 1);
    chk("R6 pulse width", dbl, 0);
    chk("R6 idle after done", {31'b0, busy_o}, 0);
  endtask

  task automatic t_maxlen();
    xlat = 0;
    mem[0] = mkd(F_V | F_X | F_L, 16'hFFFC, 32'hDEAD_BEE0);
    start_walk(32'h00);
    wait_idle();
    chk("R2 max len", {16'b0, xl[0]}, 32'hFFFC);
    chk("R2 full addr", xa[0], 32'hDEAD_BEE0);
    chk("R6 done max", done_seen, 1);
  endtask

  task automatic t_skip();
    xlat = 1;
    mem[12] = mkd(F_V, 16'h0010, 32'h5555_0000);
    mem[13] = mkd(F_V | F_X | F_L, 16'h0020, 32'h6666_0000);
    start_walk(32'h60);
    wait_idle();
    chk("R5 one transfer", xn, 1);
    chk("R5 addr", xa[0], 32'h6666_0000);
    chk("R5 done", done_seen, 1);
    mem[14] = mkd(F_V | F_L, 16'h0010, 32'h7777_0000);
    start_walk(32'h70);
    wait_idle();
    chk("R5 last skip no transfer", xn, 0);
    chk("R5 last skip done", done_seen, 1);
  endtask

  task automatic t_invalid();
    xlat = 0;
    mem[16] = mkd(F_V | F_X, 16'h0010, 32'h8000_0000);
    mem[17] = mkd(F_X | F_L, 16'h0010, 32'h8100_0000);
    start_walk(32'h80);
    wait_idle();
    chk("R7 transfers before bad", xn, 1);
    chk("R7 err set", {31'b0, err_o}, 1);
    chk("R7 no done", done_seen, 0);
    chk("R7 fetches", fn, 2);
  endtask

  task automatic t_misalign();
    mem[18] = mkd(F_V | F_X | F_L, 16'h0006, 32'h9000_0000);
    start_walk(32'h90);
    chk("R9 err cleared by start", {31'b0, err_o}, 0);
    wait_idle();
    chk("R8 no transfer", xn, 0);
    chk("R8 err set", {31'b0, err_o}, 1);
    chk("R8 no done", done_seen, 0);
    repeat (5) @(negedge clk);
    chk("R9 err sticky", {31'b0, err_o}, 1);
  endtask

  task automatic t_abort();
    xlat = 50;
    mem[20] = mkd(F_V | F_X, 16'h0010, 32'hA000_0000);
    mem[21] = mkd(F_V | F_X | F_L, 16'h0010, 32'hA100_0000);
    start_walk(32'hA0);
    for (int i = 0; i < 20; i++) begin
      if (xfer_req_o) break;
      @(negedge clk);
    end
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R10 idle after abort", {29'b0, busy_o, mem_req_o, xfer_req_o}, 0);
    repeat (60) @(negedge clk);
    chk("R10 no done", done_seen, 0);
    chk("R10 no transfer", xn, 0);
    chk("R10 no more fetch", fn, 1);
  endtask

  task automatic t_start_busy();
    xlat = 5;
    mem[24] = mkd(F_V | F_X, 16'h0010, 32'hC000_0000);
    mem[25] = mkd(F_V | F_X | F_L, 16'h0010, 32'hC100_0000);
    mem[28] = mkd(F_V | F_X | F_L, 16'h0010, 32'hEEEE_0000);
    start_walk(32'hC0);
    for (int i = 0; i < 20; i++) begin
      if (xfer_req_o) break;
      @(negedge clk);
    end
    start_i = 1'b1; list_base_i = 32'hE0;
    @(negedge clk);
    start_i = 1'b0; list_base_i = 32'h0;
    wait_idle();
    chk("R11 fetch count", fn, 2);
    chk("R11 second fetch", fa[1], 32'hC8);
    chk("R11 second transfer", xa[1], 32'hC100_0000);
    chk("R11 done", done_seen, 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; list_base_i = '0;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_maxlen();
    t_skip();
    t_invalid();
    t_misalign();
    t_abort();
    t_start_busy();
    finish_run();
  end
endmodule